// File: doc/BRIEF.md
# 8-bit ALU with flag logic

This block is the arithmetic and logic unit of a small 8-bit processor core. Two operands, an operation code and a 3-bit bit/shift index arrive in the same cycle. The block computes two results: an accumulator result, and a destination-register result with its write enable. It also keeps the carry (C), overflow (V) and zero (Z) flags in registers. The results are purely combinational. A flag update is committed at the rising clock edge of every cycle in which `op_en` is high.

Carry-consuming operations take their carry from the block's own C flag, so a chain of add-with-carry or subtract-with-carry operations needs no extra wiring. On every subtract, C means "no borrow". Shifts are built on the multiplier: the operand is multiplied by a power of two, and the 16-bit product is split so that its low byte goes to the accumulator and its high byte to the destination register.

Top module: `alu8_core`

## Requirements
- R1: DEC (op_code 0) gives opa-1 and DECC (op_code 1) gives opa-1+C. Both write the destination register. C becomes 1 unless a borrow occurs: for DEC that means the result is 0xFF; for DECC it means the result is 0xFF and the old C is 0. V is signed overflow and Z marks a zero result.
- R2: ADD (2) and ADDC (3) give opa+opb, and ADDC adds the current C as well. C is the carry out of bit 7, V is signed overflow and Z marks a zero result. The sum goes to both the accumulator and the destination register.
- R3: SUB (4) gives opa-opb and SUBC (5) gives opa-opb-(1-C). C=0 on underflow and C=1 otherwise; V is signed overflow and Z marks a zero result. The destination register is written.
- R4: SUBR (6) gives opb-opa and SUBRC (7) gives opb-opa-(1-C). The flag rules are the same as in R3.
- R5: MUL (8) puts the low byte of opa*opb on acc_out and the high byte on dst_out with dst_we=1. C, V and Z are not changed.
- R6: SHL (9) multiplies opa by 2^bit_idx. The low byte goes to acc_out, the high byte goes to dst_out, and the flags are not changed.
- R7: SHR (10) and SHRA (11) multiply opa by 2^(8-bit_idx), with SHRA sign-extending opa first. The split is the same as in R6, so dst_out holds opa shifted right by bit_idx. The flags are not changed.
- R8: CMP (12) puts opb-opa on acc_out and writes no register (dst_we=0, dst_out=0). C is the no-borrow bit, Z marks a zero difference and V = C AND NOT Z.
- R9: AND (13), OR (14) and XOR (15) combine opa with opb, write the result to both outputs, and update only Z. C and V keep their values.
- R10: TSTB (16) copies opa[bit_idx] into the same position of acc_out with all other bits 0. It writes no register (dst_we=0, dst_out=0) and updates only Z.
- R11: SETB (17), CLRB (18) and INVB (19) set, clear or invert opa[bit_idx] and leave the other bits unchanged. The new value goes to both outputs, and only Z is updated.
- R12: Flags change only on a rising edge with op_en=1. An asynchronous active-low reset clears C, V and Z to 0.
- R13: op_code values 20 to 31 give acc_out=0, dst_out=0 and dst_we=0, and they leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Commits the flag update at the next rising edge |
| op_code | input | 5 | Operation select (codes listed in the requirements) |
| opa | input | 8 | Register operand |
| opb | input | 8 | Second operand (immediate, memory or register) |
| bit_idx | input | 3 | Bit index or shift count |
| acc_out | output | 8 | Accumulator result |
| dst_out | output | 8 | Destination register value |
| dst_we | output | 1 | Destination register write enable |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The accumulator result, the destination value and the write enable follow their inputs in the same cycle. They are sampled 1 ns after each negative-edge drive, while the inputs are held. The flags are due at the first rising edge after the operation and are sampled 2 ns after that edge, before the next drive. Each carry-consuming vector is preceded by a preset add that puts C, V and Z in a known state, so a single walk of the vector table covers both carry-in values. Clocked properties compare each flag against the operands of the previous cycle.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_DEC   = 5'd0,
    OP_DECC  = 5'd1,
    OP_ADD   = 5'd2,
    OP_ADDC  = 5'd3,
    OP_SUB   = 5'd4,
    OP_SUBC  = 5'd5,
    OP_SUBR  = 5'd6,
    OP_SUBRC = 5'd7,
    OP_MUL   = 5'd8,
    OP_SHL   = 5'd9,
    OP_SHR   = 5'd10,
    OP_SHRA  = 5'd11,
    OP_CMP   = 5'd12,
    OP_AND   = 5'd13,
    OP_OR    = 5'd14,
    OP_XOR   = 5'd15,
    OP_TSTB  = 5'd16,
    OP_SETB  = 5'd17,
    OP_CLRB  = 5'd18,
    OP_INVB  = 5'd19
  } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder: x + y + cin, or x + ~y + cin for subtraction (carry = no borrow)
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] y_eff;
  logic [W:0]   wide;

  always_comb begin
    y_eff = sub ? ~y : y;
    wide  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_mulshift.sv
// Multiplier shared by MUL and the power-of-two shifts; product split in bytes
module alu8_mulshift
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [IDXW-1:0] idx,
  output logic [W-1:0]   lo,
  output logic [W-1:0]   hi
);
  localparam logic [2*W-1:0] ONE = {{(2*W-1){1'b0}}, 1'b1};
  localparam logic [IDXW:0]  WSH = W[IDXW:0];

  logic [IDXW:0]  rsh;
  logic [2*W-1:0] mcand, factor, prod;

  always_comb begin
    rsh    = WSH - {1'b0, idx};
    mcand  = {{W{1'b0}}, opa};
    factor = '0;
    case (op)
      OP_MUL: begin
        mcand  = {{W{1'b0}}, opb};
        factor = {{W{1'b0}}, opa};
      end
      OP_SHL:  factor = ONE << idx;
      OP_SHR:  factor = ONE << rsh;
      OP_SHRA: begin
        mcand  = {{W{opa[W-1]}}, opa};
        factor = ONE << rsh;
      end
      default: factor = '0;
    endcase
    prod = mcand * factor;
    lo   = prod[W-1:0];
    hi   = prod[2*W-1:W];
  end
endmodule

// File: rtl/alu8_bitlogic.sv
// Bitwise logic and single-bit test/set/clear/invert
module alu8_bitlogic
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [IDXW-1:0] idx,
  output logic [W-1:0]    res
);
  logic [W-1:0] mask;

  always_comb begin
    mask = {{(W-1){1'b0}}, 1'b1} << idx;
    case (op)
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_TSTB: res = opa & mask;
      OP_SETB: res = opa | mask;
      OP_CLRB: res = opa & ~mask;
      OP_INVB: res = opa ^ mask;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_en,
  input  logic [4:0]      op_code,
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [IDXW-1:0] bit_idx,
  output logic [W-1:0]    acc_out,
  output logic [W-1:0]    dst_out,
  output logic            dst_we,
  output logic            flag_c,
  output logic            flag_v,
  output logic            flag_z
);
  alu_op_e op;
  assign op = alu_op_e'(op_code);

  // adder operand routing
  logic [W-1:0] as_x, as_y, as_sum;
  logic         as_sub, as_cin, as_c, as_v;

  always_comb begin
    as_x   = opa;
    as_y   = opb;
    as_sub = 1'b1;
    as_cin = 1'b1;
    case (op)
      OP_DEC:   begin as_y = '0; as_cin = 1'b0;   end
      OP_DECC:  begin as_y = '0; as_cin = flag_c; end
      OP_ADD:   begin as_sub = 1'b0; as_cin = 1'b0;   end
      OP_ADDC:  begin as_sub = 1'b0; as_cin = flag_c; end
      OP_SUBC:  as_cin = flag_c;
      OP_SUBR, OP_CMP: begin as_x = opb; as_y = opa; end
      OP_SUBRC: begin as_x = opb; as_y = opa; as_cin = flag_c; end
      default:  as_cin = 1'b1;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(as_x), .y(as_y), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_c), .ovf(as_v)
  );

  logic [W-1:0] ms_lo, ms_hi, bl_res;

  alu8_mulshift #(.W(W), .IDXW(IDXW)) u_mulshift (
    .op(op), .opa(opa), .opb(opb), .idx(bit_idx), .lo(ms_lo), .hi(ms_hi)
  );

  alu8_bitlogic #(.W(W), .IDXW(IDXW)) u_bitlogic (
    .op(op), .opa(opa), .opb(opb), .idx(bit_idx), .res(bl_res)
  );

  // result selection and next flag values
  logic c_nxt, v_nxt, z_nxt;

  always_comb begin
    acc_out = '0;
    dst_out = '0;
    dst_we  = 1'b0;
    c_nxt   = flag_c;
    v_nxt   = flag_v;
    z_nxt   = flag_z;
    case (op)
      OP_DEC, OP_DECC, OP_ADD, OP_ADDC,
      OP_SUB, OP_SUBC, OP_SUBR, OP_SUBRC: begin
        acc_out = as_sum;
        dst_out = as_sum;
        dst_we  = 1'b1;
        c_nxt   = as_c;
        v_nxt   = as_v;
        z_nxt   = (as_sum == '0);
      end
      OP_CMP: begin
        acc_out = as_sum;
        c_nxt   = as_c;
        z_nxt   = (as_sum == '0);
        v_nxt   = as_c & (as_sum != '0);
      end
      OP_MUL, OP_SHL, OP_SHR, OP_SHRA: begin
        acc_out = ms_lo;
        dst_out = ms_hi;
        dst_we  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_SETB, OP_CLRB, OP_INVB: begin
        acc_out = bl_res;
        dst_out = bl_res;
        dst_we  = 1'b1;
        z_nxt   = (bl_res == '0);
      end
      OP_TSTB: begin
        acc_out = bl_res;
        z_nxt   = (bl_res == '0);
      end
      default: acc_out = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
    end else if (op_en) begin
      flag_c <= c_nxt;
      flag_v <= v_nxt;
      flag_z <= z_nxt;
    end
  end

  // flag behaviour checks
  assert_dec_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_DEC) |=> (flag_c == ($past(opa) != '0)));

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_ADD) |=> (flag_c == ($past(opa) > ~$past(opb))));

  assert_sub_noborrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_SUB) |=> (flag_c == ($past(opa) >= $past(opb))));

  assert_mul_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op == OP_MUL || op == OP_SHL || op == OP_SHR || op == OP_SHRA))
    |=> ($stable(flag_c) && $stable(flag_v) && $stable(flag_z)));

  assert_shl_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHL) |-> ({dst_out, acc_out} == ({{W{1'b0}}, opa} << bit_idx)));

  assert_cmp_vrule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_CMP) |=> (flag_v == (flag_c && !flag_z)));

  assert_logic_keeps_cv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op == OP_AND || op == OP_OR || op == OP_XOR))
    |=> ($stable(flag_c) && $stable(flag_v)));

  assert_tstb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TSTB) |-> ($onehot0(acc_out) && acc_out[bit_idx] == opa[bit_idx]));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_en) |=> ($stable(flag_c) && $stable(flag_v) && $stable(flag_z)));
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  import alu8_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_en = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] acc_out, dst_out;
  logic       dst_we, flag_c, flag_v, flag_z;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .opa(opa), .opb(opb), .bit_idx(bit_idx),
    .acc_out(acc_out), .dst_out(dst_out), .dst_we(dst_we),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
  );

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] idx;
    logic       cpre;   // 1: preset flags C1 V0 Z1, 0: preset C0 V0 Z0
    logic [3:0] rq;
    logic [7:0] acc;
    logic [7:0] dst;
    logic       we;
    logic       c;
    logic       v;
    logic       z;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_DEC,   8'h00, 8'h00, 3'd0, 1'b0, 4'd1,  8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R1
    '{OP_DEC,   8'h80, 8'h00, 3'd0, 1'b1, 4'd1,  8'h7F, 8'h7F, 1'b1, 1'b1, 1'b1, 1'b0}, // R1
    '{OP_DECC,  8'h00, 8'h00, 3'd0, 1'b0, 4'd1,  8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R1
    '{OP_DECC,  8'h00, 8'h00, 3'd0, 1'b1, 4'd1,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{OP_ADD,   8'hC8, 8'h64, 3'd0, 1'b0, 4'd2,  8'h2C, 8'h2C, 1'b1, 1'b1, 1'b0, 1'b0}, // R2
    '{OP_ADDC,  8'h7F, 8'h00, 3'd0, 1'b1, 4'd2,  8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0}, // R2
    '{OP_ADDC,  8'hFF, 8'h00, 3'd0, 1'b1, 4'd2,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R2
    '{OP_SUB,   8'h05, 8'h07, 3'd0, 1'b0, 4'd3,  8'hFE, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{OP_SUB,   8'h07, 8'h07, 3'd0, 1'b0, 4'd3,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R3
    '{OP_SUBC,  8'h10, 8'h0F, 3'd0, 1'b0, 4'd3,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R3
    '{OP_SUBR,  8'h01, 8'h80, 3'd0, 1'b1, 4'd4,  8'h7F, 8'h7F, 1'b1, 1'b1, 1'b1, 1'b0}, // R4
    '{OP_SUBRC, 8'h00, 8'h00, 3'd0, 1'b0, 4'd4,  8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    '{OP_MUL,   8'hFF, 8'hFF, 3'd0, 1'b1, 4'd5,  8'h01, 8'hFE, 1'b1, 1'b1, 1'b0, 1'b1}, // R5
    '{OP_SHL,   8'hB5, 8'h00, 3'd3, 1'b0, 4'd6,  8'hA8, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{OP_SHR,   8'hB5, 8'h00, 3'd3, 1'b1, 4'd7,  8'hA0, 8'h16, 1'b1, 1'b1, 1'b0, 1'b1}, // R7
    '{OP_SHRA,  8'hB5, 8'h00, 3'd3, 1'b0, 4'd7,  8'hA0, 8'hF6, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
    '{OP_SHR,   8'hB5, 8'h00, 3'd0, 1'b0, 4'd7,  8'h00, 8'hB5, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
    '{OP_CMP,   8'h30, 8'h50, 3'd0, 1'b0, 4'd8,  8'h20, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R8
    '{OP_CMP,   8'h50, 8'h30, 3'd0, 1'b1, 4'd8,  8'hE0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{OP_CMP,   8'h42, 8'h42, 3'd0, 1'b0, 4'd8,  8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R8
    '{OP_AND,   8'hF0, 8'h0F, 3'd0, 1'b1, 4'd9,  8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R9
    '{OP_OR,    8'hF0, 8'h0F, 3'd0, 1'b1, 4'd9,  8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R9
    '{OP_XOR,   8'hAA, 8'hAA, 3'd0, 1'b0, 4'd9,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R9
    '{OP_TSTB,  8'h08, 8'h00, 3'd3, 1'b1, 4'd10, 8'h08, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
    '{OP_TSTB,  8'hF7, 8'h00, 3'd3, 1'b0, 4'd10, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R10
    '{OP_SETB,  8'h00, 8'h00, 3'd7, 1'b0, 4'd11, 8'h80, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0}, // R11
    '{OP_CLRB,  8'h01, 8'h00, 3'd0, 1'b1, 4'd11, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R11
    '{OP_INVB,  8'hFF, 8'h00, 3'd4, 1'b0, 4'd11, 8'hEF, 8'hEF, 1'b1, 1'b0, 1'b0, 1'b0}, // R11
    '{5'd31,    8'h12, 8'h34, 3'd0, 1'b1, 4'd13, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}  // R13
  };

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] idx, input logic en);
    @(negedge clk);
    op_code = op;
    opa     = a;
    opb     = b;
    bit_idx = idx;
    op_en   = en;
  endtask

  // known flag state: cset=1 -> C1 V0 Z1 (FF+01), cset=0 -> C0 V0 Z0 (00+01)
  task automatic preset(input logic cset);
    drive(OP_ADD, cset ? 8'hFF : 8'h00, 8'h01, 3'd0, 1'b1);
    @(posedge clk);
  endtask

  task automatic check_flags(input string tag, input logic c, input logic v, input logic z);
    chk({tag, " C"}, {7'd0, flag_c}, {7'd0, c});
    chk({tag, " V"}, {7'd0, flag_v}, {7'd0, v});
    chk({tag, " Z"}, {7'd0, flag_z}, {7'd0, z});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    #2;
    check_flags("R12 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check_flags("R12 after reset", 1'b0, 1'b0, 1'b0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      vec_t t;
      t = VECS[k];
      preset(t.cpre);
      drive(t.op, t.a, t.b, t.idx, 1'b1);
      #1;
      chk($sformatf("R%0d vec%0d acc", t.rq, k), acc_out, t.acc);
      chk($sformatf("R%0d vec%0d dst", t.rq, k), dst_out, t.dst);
      chk($sformatf("R%0d vec%0d we", t.rq, k), {7'd0, dst_we}, {7'd0, t.we});
      @(posedge clk);
      #2;
      check_flags($sformatf("R%0d vec%0d", t.rq, k), t.c, t.v, t.z);
    end

    // R2 boundary: 80+80 wraps to zero with carry and signed overflow
    preset(1'b0);
    drive(OP_ADD, 8'h80, 8'h80, 3'd0, 1'b1);
    #1;
    chk("R2 80+80 acc", acc_out, 8'h00);
    @(posedge clk);
    #2;
    check_flags("R2 80+80", 1'b1, 1'b1, 1'b1);

    // R6 boundary: shift by 7
    drive(OP_SHL, 8'hFF, 8'h00, 3'd7, 1'b1);
    #1;
    chk("R6 shl7 acc", acc_out, 8'h80);
    chk("R6 shl7 dst", dst_out, 8'h7F);

    // R7 boundary: arithmetic right by 7 of a negative value
    drive(OP_SHRA, 8'h80, 8'h00, 3'd7, 1'b1);
    #1;
    chk("R7 shra7 acc", acc_out, 8'h00);
    chk("R7 shra7 dst", dst_out, 8'hFF);

    // R12: op_en low holds the flags
    preset(1'b1);
    drive(OP_SUB, 8'h00, 8'h01, 3'd0, 1'b0);
    #1;
    chk("R12 idle acc", acc_out, 8'hFF);
    @(posedge clk);
    #2;
    check_flags("R12 idle hold", 1'b1, 1'b0, 1'b1);

    // R12: asynchronous reset clears flags mid-run
    preset(1'b1);
    @(negedge clk);
    op_en = 1'b0;
    rst_n = 1'b0;
    #2;
    check_flags("R12 async reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule